// File: doc/BRIEF.md
# FM Tuning Word Generator

This block turns a stream of stereo audio samples into the frequency words that drive a byte-loaded direct digital synthesizer, so that the synthesizer output is frequency modulated by the audio. For each accepted sample pair, each channel is halved, the two halves are summed, and the sum is scaled by a deviation constant. The result is offset by a center-frequency word, and all of this arithmetic is done at the full tuning-word width.

The computed word then leaves the block one byte at a time over an 8-bit bus. Each byte is marked by a single-cycle write strobe. Once the last byte is out, a single-cycle update strobe tells the synthesizer to apply the new word. Audio arrives far more slowly than the transfer takes, but a one-entry holding slot still absorbs a sample that arrives during a transfer. A sticky overrun flag records any sample that was lost because it was overwritten.

Top module: `fmtw_gen`

## Requirements
- R1: After synchronous reset, syn_data is 0, and syn_wclk, syn_fqud, busy and overrun are all low.
- R2: Each channel is halved by an arithmetic right shift by one, which rounds toward minus infinity, so -3 becomes -2. The two halves are added as a signed SAMPLE_W value that cannot overflow, even when both inputs are at full scale.
- R3: The tuning word is center_word plus the signed product of the halved sum and the unsigned deviation, taken modulo 2^WORD_W.
- R4: Every sample produces exactly WORD_W/BYTE_W write strobes and then one update strobe. The bytes go out most significant first.
- R5: syn_wclk is high for exactly one cycle. syn_data holds the same value in the cycle before the strobe, in the strobe cycle and in the cycle after it.
- R6: syn_fqud is high for one cycle, two cycles after the last write strobe of a word, and it is never high in the same cycle as syn_wclk.
- R7: When a sample is accepted while the block is idle, busy goes high the next cycle. It stays high for 3*(WORD_W/BYTE_W)+1 cycles, which is 13 at the defaults, and the last of those cycles is the update strobe.
- R8: A sample that arrives during a transfer is kept. It is sent directly after the update strobe, and busy does not drop between the two words.
- R9: A second sample that arrives while one is already waiting replaces it, so the replaced word is never sent. This sets overrun, which stays high until reset.
- R10: center_word and deviation are sampled in the cycle a sample arrives. Changing them afterwards does not change that sample's word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | One-cycle pulse marking a new sample pair |
| smp_left | input | SAMPLE_W | Left channel, two's complement |
| smp_right | input | SAMPLE_W | Right channel, two's complement |
| center_word | input | WORD_W | Center frequency tuning word |
| deviation | input | DEV_W | Unsigned deviation scale |
| syn_data | output | BYTE_W | Byte bus to the synthesizer |
| syn_wclk | output | 1 | Byte write strobe |
| syn_fqud | output | 1 | Frequency update strobe |
| busy | output | 1 | Transfer in progress |
| overrun | output | 1 | Sticky lost-sample flag |

## Verification
The bench uses the default parameters: 16-bit samples, a 16-bit deviation and a 32-bit word sent as four bytes. With these widths, full-scale inputs and the largest deviation push the product into 32-bit wrap-around. A transfer is only 13 cycles long, so the bench can place samples inside a running transfer to cover both the holding slot and the overwrite case. Odd negative inputs show the rounding of the halving step.

// File: rtl/fmtw_pkg.sv
package fmtw_pkg;

    // Byte sequencer phases
    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_SETUP,
        SQ_STROBE,
        SQ_HOLD,
        SQ_UPDATE
    } sq_state_t;

    // Strobes presented to the synthesizer
    typedef struct packed {
        logic wclk;
        logic fqud;
    } strobe_t;

    // Index width for a count of n items, at least one bit
    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/fmtw_word_calc.sv
module fmtw_word_calc #(
    parameter int SAMPLE_W = 16,
    parameter int DEV_W    = 16,
    parameter int WORD_W   = 32
) (
    input  logic [SAMPLE_W-1:0] left,
    input  logic [SAMPLE_W-1:0] right,
    input  logic [WORD_W-1:0]   center,
    input  logic [DEV_W-1:0]    dev,
    output logic [WORD_W-1:0]   word
);
    localparam int SEXT_W = WORD_W - SAMPLE_W;
    localparam int ZEXT_W = WORD_W - DEV_W;

    logic signed [SAMPLE_W-1:0] half_l, half_r, mix;
    logic        [WORD_W-1:0]   mix_ext, dev_ext, prod;

    always_comb begin
        half_l  = $signed(left) >>> 1;
        half_r  = $signed(right) >>> 1;
        mix     = half_l + half_r;
        mix_ext = {{SEXT_W{mix[SAMPLE_W-1]}}, mix};
        dev_ext = {{ZEXT_W{1'b0}}, dev};
        prod    = mix_ext * dev_ext;
        word    = center + prod;
    end
endmodule

// File: rtl/fmtw_hold_slot.sv
module fmtw_hold_slot #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [WORD_W-1:0] wr_word,
    input  logic              rd,
    output logic              vld,
    output logic [WORD_W-1:0] word,
    output logic              overrun
);
    always_ff @(posedge clk) begin
        if (rst) begin
            vld     <= 1'b0;
            word    <= '0;
            overrun <= 1'b0;
        end else begin
            if (wr) begin
                word <= wr_word;
                vld  <= 1'b1;
                if (vld && !rd)
                    overrun <= 1'b1;
            end else if (rd) begin
                vld <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/fmtw_byte_seq.sv
module fmtw_byte_seq
    import fmtw_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WORD_W-1:0] load_word,
    output logic              ready,
    output logic              busy,
    output logic [BYTE_W-1:0] data,
    output strobe_t           strb
);
    localparam int NBYTES = WORD_W / BYTE_W;
    localparam int IDX_W  = idx_width(NBYTES);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NBYTES - 1);

    sq_state_t         state;
    logic [WORD_W-1:0] shreg;
    logic [IDX_W-1:0]  idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SQ_IDLE;
            shreg <= '0;
            idx   <= '0;
        end else begin
            case (state)
                SQ_IDLE, SQ_UPDATE: begin
                    if (load) begin
                        shreg <= load_word;
                        idx   <= '0;
                        state <= SQ_SETUP;
                    end else begin
                        state <= SQ_IDLE;
                    end
                end
                SQ_SETUP:  state <= SQ_STROBE;
                SQ_STROBE: state <= SQ_HOLD;
                SQ_HOLD: begin
                    if (idx == LAST_IDX) begin
                        state <= SQ_UPDATE;
                    end else begin
                        idx   <= idx + 1'b1;
                        shreg <= shreg << BYTE_W;
                        state <= SQ_SETUP;
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    always_comb begin
        ready     = (state == SQ_IDLE) || (state == SQ_UPDATE);
        busy      = (state != SQ_IDLE);
        data      = shreg[WORD_W-1 -: BYTE_W];
        strb.wclk = (state == SQ_STROBE);
        strb.fqud = (state == SQ_UPDATE);
    end
endmodule

// File: rtl/fmtw_gen.sv
module fmtw_gen
    import fmtw_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int DEV_W    = 16,
    parameter int WORD_W   = 32,
    parameter int BYTE_W   = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_left,
    input  logic [SAMPLE_W-1:0] smp_right,
    input  logic [WORD_W-1:0]   center_word,
    input  logic [DEV_W-1:0]    deviation,
    output logic [BYTE_W-1:0]   syn_data,
    output logic                syn_wclk,
    output logic                syn_fqud,
    output logic                busy,
    output logic                overrun
);
    logic [WORD_W-1:0] new_word, slot_word, seq_word;
    logic              slot_vld, seq_ready, seq_load;
    logic              direct, slot_wr, slot_rd;
    strobe_t           strb;

    fmtw_word_calc #(
        .SAMPLE_W(SAMPLE_W), .DEV_W(DEV_W), .WORD_W(WORD_W)
    ) calc_i (
        .left(smp_left), .right(smp_right),
        .center(center_word), .dev(deviation),
        .word(new_word)
    );

    // Waiting sample has priority; a new one goes straight through only
    // when nothing waits and the sequencer can take a word.
    always_comb begin
        direct   = smp_valid && seq_ready && !slot_vld;
        slot_wr  = smp_valid && !direct;
        slot_rd  = seq_ready && slot_vld;
        seq_load = direct || slot_rd;
        seq_word = slot_vld ? slot_word : new_word;
    end

    fmtw_hold_slot #(.WORD_W(WORD_W)) slot_i (
        .clk(clk), .rst(rst),
        .wr(slot_wr), .wr_word(new_word), .rd(slot_rd),
        .vld(slot_vld), .word(slot_word), .overrun(overrun)
    );

    fmtw_byte_seq #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) seq_i (
        .clk(clk), .rst(rst),
        .load(seq_load), .load_word(seq_word),
        .ready(seq_ready), .busy(busy),
        .data(syn_data), .strb(strb)
    );

    assign syn_wclk = strb.wclk;
    assign syn_fqud = strb.fqud;
endmodule

// File: rtl/fmtw_gen_chk.sv
module fmtw_gen_chk #(
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              smp_valid,
    input logic              busy,
    input logic [BYTE_W-1:0] syn_data,
    input logic              syn_wclk,
    input logic              syn_fqud,
    input logic              overrun
);
    a_r5_wclk_single: assert property (@(posedge clk) disable iff (rst)
        syn_wclk |=> !syn_wclk);

    a_r5_setup_stable: assert property (@(posedge clk) disable iff (rst)
        $rose(syn_wclk) |-> $stable(syn_data));

    a_r5_hold_stable: assert property (@(posedge clk) disable iff (rst)
        $fell(syn_wclk) |-> $stable(syn_data));

    a_r6_no_coincide: assert property (@(posedge clk) disable iff (rst)
        !(syn_wclk && syn_fqud));

    a_r6_update_after_byte: assert property (@(posedge clk) disable iff (rst)
        syn_fqud |-> $past(syn_wclk, 2));

    a_r6_update_single: assert property (@(posedge clk) disable iff (rst)
        syn_fqud |=> !syn_fqud);

    a_r7_busy_on_accept: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && !busy) |=> busy);

    a_r7_busy_in_update: assert property (@(posedge clk) disable iff (rst)
        syn_fqud |-> busy);

    a_r9_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
        overrun |=> overrun);
endmodule

bind fmtw_gen fmtw_gen_chk #(.BYTE_W(BYTE_W)) chk_i (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .busy(busy),
    .syn_data(syn_data), .syn_wclk(syn_wclk), .syn_fqud(syn_fqud),
    .overrun(overrun)
);

// File: tb/fmtw_gen_tb_top.sv
`timescale 1ns/1ps
module fmtw_gen_tb_top;
    localparam int SAMPLE_W = 16;
    localparam int DEV_W    = 16;
    localparam int WORD_W   = 32;
    localparam int BYTE_W   = 8;
    localparam int NBYTES   = WORD_W / BYTE_W;
    localparam int XFER     = 3 * NBYTES + 1;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                smp_valid = 1'b0;
    logic [SAMPLE_W-1:0] smp_left = '0, smp_right = '0;
    logic [WORD_W-1:0]   center_word = '0;
    logic [DEV_W-1:0]    deviation = '0;
    logic [BYTE_W-1:0]   syn_data;
    logic                syn_wclk, syn_fqud, busy, overrun;

    int checks = 0, errors = 0, mon_checks = 0, mon_errors = 0;

    fmtw_gen #(.SAMPLE_W(SAMPLE_W), .DEV_W(DEV_W), .WORD_W(WORD_W), .BYTE_W(BYTE_W)) dut_i (
        .clk(clk), .rst(rst), .smp_valid(smp_valid),
        .smp_left(smp_left), .smp_right(smp_right),
        .center_word(center_word), .deviation(deviation),
        .syn_data(syn_data), .syn_wclk(syn_wclk), .syn_fqud(syn_fqud),
        .busy(busy), .overrun(overrun)
    );

    always #4 clk = ~clk;

    // Bus monitor: assembles words and checks strobe framing (R4, R5)
    logic [WORD_W-1:0] rx_words [0:63];
    int                rx_cnt = 0;
    logic [WORD_W-1:0] acc = '0;
    int                nby = 0;
    logic              prev_wclk = 1'b0;
    logic [BYTE_W-1:0] prev_data = '0;

    always @(negedge clk) begin
        if (rst) begin
            nby = 0;
            prev_wclk = 1'b0;
            prev_data = syn_data;
        end else begin
            if (syn_wclk) begin
                mon_checks++;
                if (prev_wclk || syn_data !== prev_data) begin
                    mon_errors++;
                    $display("FAIL R5 setup/width: data=%h expected %h, prev_wclk=%0d expected 0",
                             syn_data, prev_data, prev_wclk);
                end
                acc = {acc[WORD_W-BYTE_W-1:0], syn_data};
                nby++;
            end
            if (prev_wclk && !syn_wclk) begin
                mon_checks++;
                if (syn_data !== prev_data) begin
                    mon_errors++;
                    $display("FAIL R5 hold: data=%h expected %h", syn_data, prev_data);
                end
            end
            if (syn_fqud) begin
                mon_checks++;
                if (nby != NBYTES) begin
                    mon_errors++;
                    $display("FAIL R4 byte count: got %0d expected %0d", nby, NBYTES);
                end
                rx_words[rx_cnt] = acc;
                rx_cnt++;
                nby = 0;
            end
            prev_wclk = syn_wclk;
            prev_data = syn_data;
        end
    end

    function automatic logic [WORD_W-1:0] model(input logic [SAMPLE_W-1:0] l, r,
                                                input logic [WORD_W-1:0] c,
                                                input logic [DEV_W-1:0] d);
        longint s;
        longint p;
        s = (longint'($signed(l)) >>> 1) + (longint'($signed(r)) >>> 1);
        p = s * longint'({1'b0, d});
        return WORD_W'(longint'(c) + p);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [WORD_W-1:0] act, exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [SAMPLE_W-1:0] l, r);
        smp_valid = 1'b1;
        smp_left  = l;
        smp_right = r;
    endtask

    task automatic wait_idle(output int cnt);
        cnt = 0;
        while (busy) begin
            cnt++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(syn_data == '0 && !syn_wclk && !syn_fqud && !busy && !overrun,
            "R1 reset outputs", {syn_data, syn_wclk, syn_fqud, busy, overrun}, '0);
        rst = 1'b0;
        @(negedge clk);
    endtask

    // One sample from idle: word value, byte order, busy length, update timing
    task automatic t_single(input logic [SAMPLE_W-1:0] l, r,
                            input logic [WORD_W-1:0] c, input logic [DEV_W-1:0] d,
                            input string req);
        int base, cnt, fq_at;
        logic [WORD_W-1:0] exp;
        base = rx_cnt;
        exp = model(l, r, c, d);
        center_word = c;
        deviation = d;
        drive(l, r);
        @(negedge clk);
        smp_valid = 1'b0;
        chk(busy, "R7 busy after accept", 32'(busy), 32'd1);
        chk(syn_data == exp[WORD_W-1 -: BYTE_W], "R4 first byte is MSB",
            32'(syn_data), 32'(exp[WORD_W-1 -: BYTE_W]));
        cnt = 0;
        fq_at = -1;
        while (busy && cnt < 100) begin
            if (syn_fqud) fq_at = cnt;
            cnt++;
            @(negedge clk);
        end
        chk(cnt == XFER, "R7 busy length", 32'(cnt), 32'(XFER));
        chk(fq_at == XFER - 1, "R6 update in last busy cycle", 32'(fq_at), 32'(XFER - 1));
        chk(rx_cnt == base + 1 && rx_words[base] == exp, req, rx_words[base], exp);
    endtask

    task automatic t_back_to_back;
        int base, cnt;
        logic [WORD_W-1:0] ea, eb;
        base = rx_cnt;
        center_word = 32'h1000_0000;
        deviation = 16'd500;
        ea = model(16'd4000, 16'd2000, 32'h1000_0000, 16'd500);
        eb = model(-16'sd100, 16'd7, 32'h1000_0000, 16'd500);
        drive(16'd4000, 16'd2000);
        @(negedge clk);
        drive(-16'sd100, 16'd7);
        @(negedge clk);
        smp_valid = 1'b0;
        wait_idle(cnt);
        cnt = cnt + 1;
        chk(cnt == 2 * XFER, "R8 busy continuous over two words", 32'(cnt), 32'(2 * XFER));
        chk(rx_cnt == base + 2, "R8 two words sent", 32'(rx_cnt - base), 32'd2);
        chk(rx_words[base] == ea, "R8 first word", rx_words[base], ea);
        chk(rx_words[base + 1] == eb, "R8 buffered word", rx_words[base + 1], eb);
        chk(!overrun, "R8 no overrun with one waiting", 32'(overrun), 32'd0);
    endtask

    task automatic t_overrun;
        int base, cnt;
        logic [WORD_W-1:0] ea, ec;
        base = rx_cnt;
        center_word = 32'h0800_0000;
        deviation = 16'd3;
        ea = model(16'd10, 16'd20, 32'h0800_0000, 16'd3);
        ec = model(16'd30, 16'd40, 32'h0800_0000, 16'd3);
        drive(16'd10, 16'd20);
        @(negedge clk);
        drive(16'd555, 16'd666);
        @(negedge clk);
        drive(16'd30, 16'd40);
        @(negedge clk);
        smp_valid = 1'b0;
        chk(overrun, "R9 overrun set", 32'(overrun), 32'd1);
        wait_idle(cnt);
        chk(rx_cnt == base + 2, "R9 replaced word not sent", 32'(rx_cnt - base), 32'd2);
        chk(rx_words[base] == ea, "R9 first word", rx_words[base], ea);
        chk(rx_words[base + 1] == ec, "R9 newest word kept", rx_words[base + 1], ec);
        repeat (3) @(negedge clk);
        chk(overrun, "R9 overrun sticky", 32'(overrun), 32'd1);
        t_reset();
        chk(!overrun, "R9 overrun cleared by reset", 32'(overrun), 32'd0);
    endtask

    task automatic t_cfg_change;
        int base, cnt;
        logic [WORD_W-1:0] ea, eb;
        base = rx_cnt;
        center_word = 32'h2222_0000;
        deviation = 16'd40;
        ea = model(16'd1234, 16'd4321, 32'h2222_0000, 16'd40);
        eb = model(16'd1234, 16'd4321, 32'h7777_0000, 16'd9);
        drive(16'd1234, 16'd4321);
        @(negedge clk);
        smp_valid = 1'b0;
        center_word = 32'h7777_0000;
        deviation = 16'd9;
        @(negedge clk);
        drive(16'd1234, 16'd4321);
        @(negedge clk);
        smp_valid = 1'b0;
        center_word = 32'h0;
        deviation = 16'd0;
        wait_idle(cnt);
        chk(rx_words[base] == ea, "R10 in-flight word keeps settings", rx_words[base], ea);
        chk(rx_words[base + 1] == eb, "R10 waiting word keeps settings", rx_words[base + 1], eb);
    endtask

    initial begin
        #(8 * 100000);
        mon_errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks + mon_checks + 1, errors + mon_errors);
        $finish;
    end

    initial begin
        t_reset();
        t_single(16'd1000, -16'sd2000, 32'h2000_0000, 16'd300, "R3 mixed signs");
        t_single(-16'sd32768, -16'sd32768, 32'h0000_0010, 16'hFFFF, "R2 R3 negative full scale wraps");
        t_single(16'd32767, 16'd32767, 32'hF000_0000, 16'hFFFF, "R2 positive full scale no overflow");
        t_single(-16'sd3, -16'sd1, 32'h0000_1000, 16'd1, "R2 rounding toward minus infinity");
        t_single(16'd0, 16'd0, 32'h1234_5678, 16'd999, "R3 zero audio gives center");
        t_back_to_back();
        t_overrun();
        t_cfg_change();
        repeat (4) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks + mon_checks, errors + mon_errors);
        $finish;
    end
endmodule